// File: doc/BRIEF.md
# Wide-to-Narrow Dual-Clock Split Buffer

This block carries data from a 64-bit bus running on a fast clock to a 32-bit bus running on a slower, unrelated clock. Each accepted 64-bit write is cut into its lower and upper 32-bit halves in one cycle. Each half goes into its own dual-clock FIFO lane, so the two lanes always receive data together.

On the narrow side, a small controller turns the single read request into alternating pops of the two lanes. It starts with the lower lane, then takes the upper lane, and repeats. A registered select steers the output multiplexer to the lane that was just popped. Each side sees its own flags and occupancy. Pointers cross between the domains in Gray code through two-stage synchronizers.

Typical use: a bus master on the wide side pushes 64-bit words while `wr_full` is low. A consumer on the narrow side pulls 32-bit words while `rd_empty` is low. Each side confirms its own transfers through its acknowledge.

Top module: `fws_wide2narrow`

## Requirements
- R1: A write request while `wr_full` is low is accepted, and `wr_ack` is high in the following write-clock cycle. `wr_ack` is never high after a cycle without a write request.
- R2: For each accepted 64-bit word, the narrow side returns bits [31:0] first and bits [63:32] second. Words come out in the order they were written.
- R3: A read request while `rd_empty` is low is accepted. In the following read-clock cycle, `rd_ack` is high and `rd_data` holds the popped half. `rd_ack` is never high after a cycle without a read request.
- R4: After 2**ADDR_W accepted writes with no reads, `wr_full` is high. While `wr_full` is high, a write request gives no `wr_ack` and stores nothing, so the stored words and the read order stay unchanged.
- R5: When every stored half has been read, `rd_empty` goes high. A read request while `rd_empty` is high gives no `rd_ack`.
- R6: After only the lower half of a word has been read, `rd_empty` stays low until the upper half has been read too.
- R7: `rd_count` gives the number of stored 32-bit halves that the read side has seen. It is twice the number of words seen written, minus the halves read. It is zero exactly when `rd_empty` is high.
- R8: `wr_count` gives the number of 64-bit slots that still hold at least one unread half, as seen by the write side. It equals 2**ADDR_W exactly when `wr_full` is high.
- R9: After reset, `rd_empty` is 1, `wr_full` is 0, both counts are 0 and both acknowledges are 0. The read alternation restarts at the lower half.
- R10: A slot is freed for writing only after both of its halves have been read. Reading only the lower half of the oldest word leaves `wr_full` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Wide-side clock |
| wrst | input | 1 | Synchronous active-high reset, wide side |
| wr_en | input | 1 | Write request |
| wr_data | input | 2*HALF_W | Word to store; lower half read out first |
| wr_ack | output | 1 | Write accepted in the previous cycle |
| wr_full | output | 1 | No free slot in at least one lane |
| wr_count | output | ADDR_W+1 | Occupied 64-bit slots (wide-side view) |
| rclk | input | 1 | Narrow-side clock |
| rrst | input | 1 | Synchronous active-high reset, narrow side |
| rd_en | input | 1 | Read request |
| rd_data | output | HALF_W | Popped half, valid while rd_ack is high |
| rd_ack | output | 1 | Read accepted in the previous cycle |
| rd_empty | output | 1 | Both lanes empty |
| rd_count | output | ADDR_W+2 | Stored halves (narrow-side view) |

## Verification
The first pattern is a single word whose two halves differ. Reading it half by half shows whether the lanes are wired and muxed in the right order, and whether empty rises only after the second half. The second pattern is a fill to capacity with an extra write. Its data encodes the slot index in both halves, so a dropped, repeated or overwritten word shows up at once in the read order. This pattern also shows that a half-drained slot still blocks the writer. The last pattern is concurrent traffic, where the writer obeys full and the reader obeys empty. It separates correct pointer crossing from a design that only works in bursts.

// File: rtl/fws_pkg.sv
package fws_pkg;
  // Which lane the narrow side pops next
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/fws_sync.sv
module fws_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fws_async_fifo.sv
module fws_async_fifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [AW:0]   wcnt,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [AW:0]   rcnt
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, wbin_n, wgray_n;
  logic [PW-1:0] rbin, rgray, rbin_n, rgray_n;
  logic [PW-1:0] rgray_w, wgray_r, rbin_w, wbin_r;
  logic          wfire, rfire, full_n, empty_n;

  // ---------------- write domain ----------------
  assign wfire   = we & ~full;
  assign wbin_n  = wbin + PW'(wfire);
  assign wgray_n = (wbin_n >> 1) ^ wbin_n;
  assign full_n  = (wgray_n == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_comb begin
    rbin_w[PW-1] = rgray_w[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_w[i] = rbin_w[i+1] ^ rgray_w[i];
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      wcnt  <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wgray_n;
      full  <= full_n;
      wcnt  <= wbin_n - rbin_w;
    end
  end

  always_ff @(posedge wclk) begin
    if (wfire) mem[wbin[AW-1:0]] <= wdata;
  end

  fws_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
  );

  // ---------------- read domain ----------------
  assign rfire   = re & ~empty;
  assign rbin_n  = rbin + PW'(rfire);
  assign rgray_n = (rbin_n >> 1) ^ rbin_n;
  assign empty_n = (rgray_n == wgray_r);

  always_comb begin
    wbin_r[PW-1] = wgray_r[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_r[i] = wbin_r[i+1] ^ wgray_r[i];
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
      rcnt  <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rgray_n;
      empty <= empty_n;
      rcnt  <= wbin_r - rbin_n;
    end
  end

  always_ff @(posedge rclk) begin
    if (rfire) rdata <= mem[rbin[AW-1:0]];
  end

  fws_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
  );
endmodule

// File: rtl/fws_rd_ctrl.sv
module fws_rd_ctrl
  import fws_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  input  logic [1:0]        lane_empty,
  input  logic [HALF_W-1:0] q_lo,
  input  logic [HALF_W-1:0] q_hi,
  output logic [1:0]        lane_re,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_ack
);
  half_e nxt_half;   // lane to pop on the next accepted read
  half_e out_half;   // lane popped by the last accepted read
  logic  fire;

  assign lane_re[0] = rd_en & (nxt_half == HALF_LO) & ~lane_empty[0];
  assign lane_re[1] = rd_en & (nxt_half == HALF_HI) & ~lane_empty[1];
  assign fire       = |lane_re;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      nxt_half <= HALF_LO;
      out_half <= HALF_LO;
      rd_ack   <= 1'b0;
    end else begin
      rd_ack <= fire;
      if (fire) begin
        out_half <= nxt_half;
        nxt_half <= (nxt_half == HALF_LO) ? HALF_HI : HALF_LO;
      end
    end
  end

  assign rd_data = (out_half == HALF_HI) ? q_hi : q_lo;
endmodule

// File: rtl/fws_wide2narrow.sv
module fws_wide2narrow #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                wclk,
  input  logic                wrst,
  input  logic                wr_en,
  input  logic [2*HALF_W-1:0] wr_data,
  output logic                wr_ack,
  output logic                wr_full,
  output logic [ADDR_W:0]     wr_count,
  input  logic                rclk,
  input  logic                rrst,
  input  logic                rd_en,
  output logic [HALF_W-1:0]   rd_data,
  output logic                rd_ack,
  output logic                rd_empty,
  output logic [ADDR_W+1:0]   rd_count
);
  localparam int LANES = 2;

  logic [LANES-1:0]  full_v, empty_v, re_v;
  logic [HALF_W-1:0] q_v    [LANES];
  logic [ADDR_W:0]   wcnt_v [LANES];
  logic [ADDR_W:0]   rcnt_v [LANES];
  logic              wfire;

  // both lanes take the same write, so their write pointers stay equal
  assign wfire   = wr_en & ~wr_full;
  assign wr_full = |full_v;

  always_ff @(posedge wclk) begin
    if (wrst) wr_ack <= 1'b0;
    else      wr_ack <= wfire;
  end

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    fws_async_fifo #(.DW(HALF_W), .AW(ADDR_W)) u_fifo (
      .wclk (wclk),
      .wrst (wrst),
      .we   (wfire),
      .wdata(wr_data[h*HALF_W +: HALF_W]),
      .full (full_v[h]),
      .wcnt (wcnt_v[h]),
      .rclk (rclk),
      .rrst (rrst),
      .re   (re_v[h]),
      .rdata(q_v[h]),
      .empty(empty_v[h]),
      .rcnt (rcnt_v[h])
    );
  end

  // upper lane lags the lower one, so it holds the larger occupancy
  assign wr_count = (wcnt_v[0] > wcnt_v[1]) ? wcnt_v[0] : wcnt_v[1];

  assign rd_empty = &empty_v;
  assign rd_count = {1'b0, rcnt_v[0]} + {1'b0, rcnt_v[1]};

  fws_rd_ctrl #(.HALF_W(HALF_W)) u_rd_ctrl (
    .rclk      (rclk),
    .rrst      (rrst),
    .rd_en     (rd_en),
    .lane_empty(empty_v),
    .q_lo      (q_v[0]),
    .q_hi      (q_v[1]),
    .lane_re   (re_v),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int ADDR_W = 4
) (
  input logic              wclk,
  input logic              wrst,
  input logic              wr_en,
  input logic              wr_ack,
  input logic              wr_full,
  input logic [ADDR_W:0]   wr_count,
  input logic              rclk,
  input logic              rrst,
  input logic              rd_en,
  input logic              rd_ack,
  input logic              rd_empty,
  input logic [ADDR_W+1:0] rd_count
);
  localparam int DEPTH = 1 << ADDR_W;

  AST_WACK_NEEDS_REQ: assert property (@(posedge wclk) disable iff (wrst) !wr_en |=> !wr_ack); // R1
  AST_RACK_NEEDS_REQ: assert property (@(posedge rclk) disable iff (rrst) !rd_en |=> !rd_ack); // R3
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (wrst) (wr_en && wr_full) |=> !wr_ack); // R4
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (rrst) (rd_en && rd_empty) |=> !rd_ack); // R5
  AST_RCOUNT_MATCHES_EMPTY: assert property (@(posedge rclk) disable iff (rrst) rd_empty == (rd_count == '0)); // R7
  AST_RCOUNT_BOUND: assert property (@(posedge rclk) disable iff (rrst) rd_count <= (ADDR_W+2)'(2*DEPTH)); // R7
  AST_WCOUNT_MATCHES_FULL: assert property (@(posedge wclk) disable iff (wrst) wr_full == (wr_count == (ADDR_W+1)'(DEPTH))); // R8
endmodule

bind fws_wide2narrow fws_checker #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_ack(wr_ack),
  .wr_full(wr_full), .wr_count(wr_count),
  .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_ack(rd_ack),
  .rd_empty(rd_empty), .rd_count(rd_count)
);

// File: tb/tb_fws_wide2narrow.sv
`timescale 1ns/1ps
module tb_fws_wide2narrow;
  localparam int HALF_W = 32;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic                wclk = 1'b0, rclk = 1'b0;
  logic                wrst, rrst, wr_en, rd_en;
  logic [2*HALF_W-1:0] wr_data;
  logic                wr_ack, wr_full, rd_ack, rd_empty;
  logic [ADDR_W:0]     wr_count;
  logic [ADDR_W+1:0]   rd_count;
  logic [HALF_W-1:0]   rd_data;

  int checks = 0, failures = 0;

  always #2.5 wclk = ~wclk;   // 200 MHz
  always #4.0 rclk = ~rclk;

  fws_wide2narrow #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] d, output logic ack);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0; ack = wr_ack;
  endtask

  task automatic pop(output logic ack, output logic [31:0] d);
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0; ack = rd_ack; d = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic t_reset();
    wr_en = 0; rd_en = 0; wr_data = '0;
    wrst = 1; rrst = 1;
    repeat (6) @(negedge rclk);
    wrst = 0; rrst = 0;
    @(negedge rclk);
    chk("R9 rd_empty", rd_empty, 1); chk("R9 wr_full", wr_full, 0);
    chk("R9 rd_count", rd_count, 0); chk("R9 wr_count", wr_count, 0);
    chk("R9 rd_ack", rd_ack, 0);     chk("R9 wr_ack", wr_ack, 0);
  endtask

  task automatic t_single();
    logic a; logic [31:0] d;
    push(64'hA1A2A3A4_B1B2B3B4, a);
    chk("R1 wr_ack", a, 1);
    chk("R8 wr_count after write", wr_count, 1);
    settle();
    chk("R7 rd_count two halves", rd_count, 2);
    pop(a, d);
    chk("R3 rd_ack", a, 1);
    chk("R2 lower half first", d, 32'hB1B2B3B4);
    chk("R6 not empty between halves", rd_empty, 0);
    chk("R7 rd_count one half", rd_count, 1);
    pop(a, d);
    chk("R2 upper half second", d, 32'hA1A2A3A4);
    chk("R5 empty after drain", rd_empty, 1);
    pop(a, d);
    chk("R5 no ack when empty", a, 0);
    settle();
    chk("R8 wr_count back to zero", wr_count, 0);
    chk("R7 rd_count zero", rd_count, 0);
  endtask

  task automatic t_fill();
    logic a; logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      push({32'h5000_0000 + 32'(i), 32'h1000_0000 + 32'(i)}, a);
      if (i == DEPTH - 1) chk("R1 last fill write acked", a, 1);
    end
    chk("R4 full after capacity writes", wr_full, 1);
    push(64'hDEAD_DEAD_DEAD_DEAD, a);
    chk("R4 no ack when full", a, 0);
    chk("R8 wr_count at capacity", wr_count, DEPTH);
    settle();
    chk("R7 rd_count full", rd_count, 2*DEPTH);
    pop(a, d);
    chk("R2 first lower", d, 32'h1000_0000);
    settle();
    chk("R10 half-read slot not freed", wr_full, 1);
    pop(a, d);
    chk("R2 first upper", d, 32'h5000_0000);
    settle();
    chk("R10 slot freed after both halves", wr_full, 0);
    chk("R8 wr_count after one word", wr_count, DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      pop(a, d); chk("R4 order lower intact", d, 32'h1000_0000 + 32'(i));
      pop(a, d); chk("R4 order upper intact", d, 32'h5000_0000 + 32'(i));
    end
    chk("R5 empty after full drain", rd_empty, 1);
    pop(a, d);
    chk("R4 rejected word never stored", a, 0);
  endtask

  task automatic t_stream();
    localparam int N = 60;
    logic [31:0] q[$];
    int got = 0, sent = 0;
    fork
      begin
        logic [63:0] last = '0;
        for (int k = 0; k < 4000 && !(sent == N && !wr_en); k++) begin
          @(negedge wclk);
          if (wr_ack) begin q.push_back(last[31:0]); q.push_back(last[63:32]); end
          if (sent < N && !wr_full && (k % 3 != 2)) begin
            last = {32'hC000_0000 + 32'(sent), 32'h0300_0000 + 32'(sent)};
            wr_en = 1; wr_data = last; sent++;
          end else wr_en = 0;
        end
        @(negedge wclk);
        if (wr_ack) begin q.push_back(last[31:0]); q.push_back(last[63:32]); end
      end
      begin
        for (int k = 0; k < 8000 && got < 2*N; k++) begin
          @(negedge rclk);
          if (rd_ack) begin
            if (q.size() == 0) chk("R2 stream data without write", 1, 0);
            else chk("R2 stream order", rd_data, q.pop_front());
            got++;
          end
          rd_en = !rd_empty && (got < 2*N) && (k % 5 != 4);
        end
        rd_en = 0;
      end
    join
    chk("R3 stream halves received", got, 2*N);
    settle();
    chk("R5 stream ends empty", rd_empty, 1);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_fill();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule